// File: doc/BRIEF.md
# Cascaded Level Interrupt Controller with Priority Selector

This block collects 64 level-sensitive primary interrupt lines. It gives the processor one interrupt request and a selector word that names which source should be serviced. Each primary source has its own configuration register, and the register holds a 7-bit code. A source takes part in arbitration only while that code equals the build-time enable code. The enable code is 0x51 for variant 0 and 0x20 for variant 1. Any other value, including zero, keeps the source out of arbitration.

Seven fixed primary lines are not taken from the primary input pins. Each is driven by a secondary group that has its own raw status inputs and a software mask register. Several peripheral requests can therefore share one primary line. A group line stays high while any unmasked status bit is high.

Software reaches every register through a plain word-addressed register bus. Reads are combinational and writes take effect on the clock edge.

Top module: `cascade_intc`

## Requirements
- R1: The configuration register of primary source n lives at byte address 4*n (n = 0..63). It stores bits 6:0 of a write and reads back those 7 bits, with bits 31:7 reading as zero.
- R2: A primary source is considered only while its 7-bit configuration equals the variant's enable code (0x51 for VARIANT 0, 0x20 for VARIANT 1). Any other value, such as 0x50 or 0, disables it.
- R3: The selector word carries a pending flag in bit 6 and the chosen source number in bits 5:0. When no enabled source is pending, the whole word reads as zero.
- R4: When several enabled sources are pending, the selector names the lowest-numbered one.
- R5: irq_out equals the selector's pending flag. Both are registered, so they reflect source levels and configuration one clock edge after those change.
- R6: The selector word is read at byte address 0x10C for VARIANT 0 and at 0x104 for VARIANT 1. Writes to that address change nothing.
- R7: Secondary groups have 2, 2, 3, 5, 15, 2 and 2 bits, in that order. They occupy sec_lvl bits from bit 0 upward in that order, and they drive primary lines 4, 5, 9, 17, 35, 51 and 55. A group line is high exactly while some status bit is high whose mask bit is 0. A mask bit of 1 blocks its status bit.
- R8: The src_lvl bits at the seven group-driven line numbers are ignored.
- R9: The status and mask addresses are, group by group, 0x150/0x168, 0x154/0x16C, 0x180/0x17C, 0x158/0x170, 0x15C/0x174, 0x160/0x178 and 0x188/0x184. The status register reads the raw group inputs and is read-only. The mask register is read/write over the group width, and its unused bits read as zero. Unmapped addresses read zero.
- R10: While reset is low, every configuration register is 0, every mask register is all ones and irq_out is 0.
- R11: Sources are level-sensitive. When a pending level drops, the selector and irq_out follow one edge later, with no latched memory of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 64 | Primary interrupt levels |
| sec_lvl | input | 31 | Secondary group status levels, group 0 in the low bits |
| bus_addr | input | 12 | Byte address of register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A register write lands on the edge that samples it, and its read-back is visible on the following cycle. The selector and irq_out react to a change in levels, configuration or mask one further edge after that change reaches the registers. Inputs are driven just after the rising edge and sampled just before the falling edge. The behavioural model is stepped on the same rising edges and computes the selector from the state it held before each edge. The model's irq prediction and read prediction are compared on every cycle. Directed selector reads are made exactly one edge after each stimulus has settled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC  = 64;
  localparam int IDW   = $clog2(NSRC);
  localparam int CFGW  = 7;
  localparam int NGRP  = 7;
  localparam int GMAXW = 15;

  localparam int GRP_W    [NGRP] = '{2, 2, 3, 5, 15, 2, 2};
  localparam int GRP_LINE [NGRP] = '{4, 5, 9, 17, 35, 51, 55};
  localparam int GRP_STAT [NGRP] = '{'h150, 'h154, 'h180, 'h158, 'h15C, 'h160, 'h188};
  localparam int GRP_MASK [NGRP] = '{'h168, 'h16C, 'h17C, 'h170, 'h174, 'h178, 'h184};

  function automatic int grp_base(int g);
    int s;
    s = 0;
    for (int i = 0; i < g; i++) s += GRP_W[i];
    return s;
  endfunction

  localparam int SECW = grp_base(NGRP);

  function automatic logic [CFGW-1:0] en_code(int variant);
    return (variant == 0) ? 7'h51 : 7'h20;
  endfunction

  function automatic int sel_addr(int variant);
    return (variant == 0) ? 'h10C : 'h104;
  endfunction

  // line number n replaced by a secondary group? returns group or -1
  function automatic int line_group(int n);
    for (int g = 0; g < NGRP; g++)
      if (GRP_LINE[g] == n) return g;
    return -1;
  endfunction
endpackage

// File: rtl/intc_cfg_bank.sv
module intc_cfg_bank #(
  parameter int N     = 64,
  parameter int CW    = 7,
  parameter int WIW   = 10,
  parameter logic [CW-1:0] EN_CODE = 7'h51
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [WIW-1:0] word,
  input  logic [CW-1:0]  wr_data,
  output logic [CW-1:0]  rd_cfg,
  output logic [N-1:0]   enabled
);
  localparam int IW = $clog2(N);

  logic [CW-1:0] cfg_q [N];

  for (genvar n = 0; n < N; n++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[n] <= '0;
      else if (wr_en && word == WIW'(n))
        cfg_q[n] <= wr_data;
    end
    assign enabled[n] = (cfg_q[n] == EN_CODE);
  end

  assign rd_cfg = cfg_q[word[IW-1:0]];
endmodule

// File: rtl/intc_sec_group.sv
module intc_sec_group #(
  parameter int W        = 2,
  parameter int PW       = 15,
  parameter int WIW      = 10,
  parameter int MASK_WRD = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [WIW-1:0] word,
  input  logic [W-1:0]   wr_data,
  input  logic [W-1:0]   stat_in,
  output logic [PW-1:0]  mask_pad,
  output logic [PW-1:0]  stat_pad,
  output logic           line
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '1;
    else if (wr_en && word == WIW'(MASK_WRD))
      mask_q <= wr_data;
  end

  assign line     = |(stat_in & ~mask_q);
  assign mask_pad = PW'(mask_q);
  assign stat_pad = PW'(stat_in);
endmodule

// File: rtl/intc_lowest_pick.sv
module intc_lowest_pick #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req,
  output logic          vld,
  output logic [IW-1:0] id
);
  function automatic logic [IW-1:0] first_set(logic [N-1:0] v);
    for (int i = 0; i < N; i++)
      if (v[i]) return IW'(i);
    return '0;
  endfunction

  assign vld = |req;
  assign id  = first_set(req);
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import intc_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   src_lvl,
  input  logic [30:0]   sec_lvl,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_out
);
  localparam int WIW = AW - 2;
  localparam logic [CFGW-1:0] EN = en_code(VARIANT);
  localparam int SEL_WRD = sel_addr(VARIANT) / 4;

  logic [WIW-1:0]  word;
  logic [CFGW-1:0] cfg_rd;
  logic [NSRC-1:0] src_en;
  logic [NSRC-1:0] prim_lvl;
  logic [NSRC-1:0] eff_pend;
  logic [NGRP-1:0] sec_line;
  logic [GMAXW-1:0] mask_pad [NGRP];
  logic [GMAXW-1:0] stat_pad [NGRP];
  logic            pick_vld;
  logic [IDW-1:0]  pick_id;
  logic [CFGW-1:0] sel_q;

  assign word = bus_addr[AW-1:2];

  intc_cfg_bank #(.N(NSRC), .CW(CFGW), .WIW(WIW), .EN_CODE(EN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_we),
    .word    (word),
    .wr_data (bus_wdata[CFGW-1:0]),
    .rd_cfg  (cfg_rd),
    .enabled (src_en)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    intc_sec_group #(
      .W(GRP_W[g]), .PW(GMAXW), .WIW(WIW), .MASK_WRD(GRP_MASK[g] / 4)
    ) u_grp (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_we),
      .word     (word),
      .wr_data  (bus_wdata[GRP_W[g]-1:0]),
      .stat_in  (sec_lvl[grp_base(g) +: GRP_W[g]]),
      .mask_pad (mask_pad[g]),
      .stat_pad (stat_pad[g]),
      .line     (sec_line[g])
    );
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_line
    if (line_group(n) >= 0) begin : g_casc
      assign prim_lvl[n] = sec_line[line_group(n)];
    end else begin : g_pin
      assign prim_lvl[n] = src_lvl[n];
    end
  end

  assign eff_pend = prim_lvl & src_en;

  intc_lowest_pick #(.N(NSRC), .IW(IDW)) u_pick (
    .req (eff_pend),
    .vld (pick_vld),
    .id  (pick_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= pick_vld ? {1'b1, pick_id} : '0;
  end

  assign irq_out = sel_q[CFGW-1];

  always_comb begin
    bus_rdata = '0;
    if (word < WIW'(NSRC))
      bus_rdata = DW'(cfg_rd);
    else if (word == WIW'(SEL_WRD))
      bus_rdata = DW'(sel_q);
    for (int g = 0; g < NGRP; g++) begin
      if (word == WIW'(GRP_STAT[g] / 4)) bus_rdata = DW'(stat_pad[g]);
      if (word == WIW'(GRP_MASK[g] / 4)) bus_rdata = DW'(mask_pad[g]);
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic [CFGW-1:0]  sel_q,
  input logic [NSRC-1:0]  eff_pend,
  input logic             pick_vld,
  input logic [IDW-1:0]   pick_id,
  input logic [NGRP-1:0]  sec_line,
  input logic [SECW-1:0]  sec_lvl
);
  // R5
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_pend != '0) |=> irq_out);
  // R5
  irq_drops_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_pend == '0) |=> !irq_out);
  // R3
  sel_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q[CFGW-1] |-> (sel_q == '0));
  // R4
  pick_is_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> eff_pend[pick_id]);
  // R4
  pick_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> ((eff_pend & ((64'd1 << pick_id) - 64'd1)) == '0));
  // R10
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (!irq_out);
  end
  for (genvar g = 0; g < NGRP; g++) begin : g_c
    // R7
    grp_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_line[g] |-> (sec_lvl[grp_base(g) +: GRP_W[g]] != '0));
  end
endmodule

bind cascade_intc intc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_out  (irq_out),
  .sel_q    (sel_q),
  .eff_pend (eff_pend),
  .pick_vld (pick_vld),
  .pick_id  (pick_id),
  .sec_line (sec_line),
  .sec_lvl  (sec_lvl)
);

// File: tb/cascade_intc_bench.sv
`timescale 1ns/1ps
module cascade_intc_bench;
  localparam logic [6:0] EN = 7'h51;
  localparam int SEL_A = 'h10C;
  int gw [7] = '{2, 2, 3, 5, 15, 2, 2};
  int gl [7] = '{4, 5, 9, 17, 35, 51, 55};
  int gs [7] = '{'h150, 'h154, 'h180, 'h158, 'h15C, 'h160, 'h188};
  int gm [7] = '{'h168, 'h16C, 'h17C, 'h170, 'h174, 'h178, 'h184};

  logic clk = 0;
  always #5 clk = ~clk;
  logic        rst_n = 0;
  logic [63:0] src_lvl = '0;
  logic [30:0] sec_lvl = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  cascade_intc u_cascade_intc (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .sec_lvl(sec_lvl),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  int m_cfg [64];
  int m_mask [7];
  int exp_sel;
  int n_cmp = 0, n_bad = 0;

  function automatic int gbase(int g);
    int s = 0;
    for (int i = 0; i < g; i++) s += gw[i];
    return s;
  endfunction

  function automatic int gstat(int g);
    return int'((sec_lvl >> gbase(g)) & ((31'd1 << gw[g]) - 31'd1));
  endfunction

  function automatic int model_sel();
    for (int n = 0; n < 64; n++) begin
      bit lv = src_lvl[n];
      for (int g = 0; g < 7; g++)
        if (gl[g] == n) lv = ((gstat(g) & ~m_mask[g]) != 0);
      if (lv && m_cfg[n] == int'(EN)) return 64 + n;
    end
    return 0;
  endfunction

  function automatic int model_rd();
    int a = int'(bus_addr);
    if (a < 256) return m_cfg[a / 4];
    if (a == SEL_A) return exp_sel;
    for (int g = 0; g < 7; g++) begin
      if (a == gs[g]) return gstat(g);
      if (a == gm[g]) return m_mask[g];
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 64; n++) m_cfg[n] = 0;
      for (int g = 0; g < 7; g++) m_mask[g] = (1 << gw[g]) - 1;
      exp_sel = 0;
    end else begin
      exp_sel = model_sel();
      if (bus_we) begin
        if (bus_addr < 256) m_cfg[bus_addr / 4] = int'(bus_wdata & 32'h7f);
        for (int g = 0; g < 7; g++)
          if (int'(bus_addr) == gm[g]) m_mask[g] = int'(bus_wdata) & ((1 << gw[g]) - 1);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%0h)", tag, act, exp, bus_addr);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 irq", int'(irq_out), (exp_sel >> 6) & 1);
      if (bus_addr < 256)         chk("R1 cfg read", int'(bus_rdata), model_rd());
      else if (bus_addr == SEL_A) chk("R6 selector read", int'(bus_rdata), model_rd());
      else                        chk("R9 group read", int'(bus_rdata), model_rd());
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    bus_addr = 12'(a); bus_wdata = 32'(d); bus_we = 1;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic rd_expect(int a, int exp, string tag);
    bus_addr = 12'(a);
    #3;
    chk(tag, int'(bus_rdata), exp);
  endtask

  // wait one edge for the selector, then read it
  task automatic sel_expect(int exp, string tag);
    @(posedge clk); #1;
    rd_expect(SEL_A, exp, tag);
    chk({tag, " irq"}, int'(irq_out), (exp >> 6) & 1);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk("R10 irq in reset", int'(irq_out), 0);
    rd_expect('h14, 0, "R10 cfg reset");
    rd_expect('h168, 3, "R10 mask reset");
    rd_expect('h174, 'h7fff, "R10 mask reset wide");
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    wr(10 * 4, 'hFFFFFF51);
    rd_expect(10 * 4, 'h51, "R1 low seven bits");
    src_lvl[10] = 1;
    sel_expect(64 + 10, "R3 single source");

    wr(12 * 4, 'h50);
    src_lvl[12] = 1;
    wr(10 * 4, 0);
    sel_expect(0, "R2 near code disabled");
    wr(12 * 4, 'h51);
    sel_expect(64 + 12, "R2 exact code enables");

    wr(20 * 4, 'h51); wr(40 * 4, 'h51);
    src_lvl[20] = 1; src_lvl[40] = 1; src_lvl[12] = 0;
    sel_expect(64 + 20, "R4 lowest of two");
    wr(3 * 4, 'h51); src_lvl[3] = 1;
    sel_expect(64 + 3, "R4 lower wins");
    src_lvl[3] = 0;
    sel_expect(64 + 20, "R11 level drop");
    src_lvl[20] = 0; src_lvl[40] = 0;
    sel_expect(0, "R11 all dropped");

    wr(SEL_A, 'h7F);
    sel_expect(0, "R6 write ignored");

    wr(4 * 4, 'h51); src_lvl[4] = 1;
    sel_expect(0, "R8 pin on cascade line ignored");
    sec_lvl[1] = 1;
    sel_expect(0, "R7 masked status blocked");
    wr('h168, 'h1);
    sel_expect(64 + 4, "R7 unmasked status drives line 4");
    rd_expect('h150, 2, "R9 status raw");
    rd_expect('h168, 1, "R9 mask read");
    wr('h168, 'h3);
    sel_expect(0, "R7 remask");
    sec_lvl[1] = 0; src_lvl[4] = 0;

    wr(35 * 4, 'h51);
    sec_lvl[12 + 14] = 1;
    wr('h174, 'h3FFF);
    sel_expect(64 + 35, "R7 group of fifteen to line 35");
    rd_expect('h15C, 'h4000, "R9 wide status");
    sec_lvl[12 + 14] = 0;
    sel_expect(0, "R11 group level drop");
    rd_expect('h200, 0, "R9 unmapped read");

    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule